// File: doc/BRIEF.md
# Switchable-Width Down-Counting Timer

The block is a down-counting timer register. The register steps down by one on each timebase tick strobe. When its value crosses zero into negative territory, or when software writes certain values into it, it raises an interrupt. A mode input picks between two widths at run time:

- a legacy width of 32 bits, which reads back zero-extended to 64 bits;
- a wider width set by the `LARGE_W` parameter (32 to 56), which reads back sign-extended to 64 bits.

A second parameter, `HYPER`, builds the hypervisor flavour. That flavour always runs at the wide width and ignores the mode input.

Software writes a 64-bit value. The block cuts it to the active width and sign-extends it from the top bit of that width. The interrupt follows one of two rules, picked by an input:

- Level rule: the interrupt is set by writing a negative value and cleared by writing a non-negative one.
- Edge rule: a latched flag is set only when a write turns the value from non-negative to negative. Only the acknowledge input clears it.

In both rules, a written value of 0, 1 or 2 fires at once, and a tick that wraps the active field from zero to all-ones also fires.

Top module: `dec_timer`

## Requirements
- R1: After reset, with wide mode off, `rd_data` reads 0x00000000FFFFFFFF and `irq` is 0.
- R2: With wide mode off, each `tick` cycle without a write lowers the count by one, and `rd_data[63:32]` reads 0.
- R3: With wide mode on, `rd_data` is the stored `LARGE_W`-bit count sign-extended from bit `LARGE_W`-1.
- R4: A write keeps only the low bits of `wr_data` for the active width (32, or `LARGE_W` in wide mode) and sign-extends them from the top kept bit. The value stays sign-extended when read in the other mode.
- R5: A write whose value after folding is 0, 1 or 2 sets `irq` on the next cycle, under either interrupt rule.
- R6: With `irq_edge`=0 (level rule), a write with the top active bit set sets `irq`. A write of a non-negative value of 3 or more clears it. `irq_ack` has no effect.
- R7: With `irq_edge`=1 (edge rule), a negative write sets `irq` only if the previous value's top active bit was 0. Non-negative writes leave `irq` unchanged. `irq_ack` clears it.
- R8: A tick that moves the active-width field from zero to all-ones sets `irq`, under either rule.
- R9: In a cycle with both `wr_en` and `tick`, the written value is stored and the tick is dropped.
- R10: With `HYPER`=1, the counter always uses the `LARGE_W` width and sign-extended reads, whatever the value of `large_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick strobe, one decrement per cycle high |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Value to load |
| large_mode | input | 1 | 1 selects the wide width (ignored when HYPER=1) |
| irq_edge | input | 1 | Interrupt rule: 0 level, 1 edge |
| irq_ack | input | 1 | Acknowledge, clears the edge-rule flag |
| rd_data | output | 64 | Current count, extended to 64 bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two instances.

The first uses `LARGE_W`=40 with `HYPER`=0. Because the wide sign bit is then bit 39, it is clearly apart from bit 31, so one stored value read in both modes shows the difference between zero- and sign-extension. This instance also lets a write set bit 39 while bits 40 to 63 are clear, which tests the truncation.

The second uses `HYPER`=1 with `LARGE_W`=56, the top legal width, and holds `large_mode` low. This shows that the wide behaviour is forced and that the sign comes from bit 55.

// File: rtl/dect_pkg.sv
package dect_pkg;
  localparam int unsigned LEGACY_W  = 32;
  localparam int unsigned HYP_MAX_W = 56;

  // Ones in the low w bit positions.
  function automatic logic [63:0] width_mask(input int unsigned w);
    logic [63:0] m;
    for (int unsigned i = 0; i < 64; i++) m[i] = (i < w);
    return m;
  endfunction

  // Keep the low w bits of v, then copy bit w-1 into every higher bit.
  function automatic logic [63:0] fold_to_width(input logic [63:0] v, input int unsigned w);
    logic [63:0] r;
    logic        s;
    s = v[6'(w - 1)];
    for (int unsigned i = 0; i < 64; i++) r[i] = (i < w) ? v[i] : s;
    return r;
  endfunction

  // Value seen at the read port: sign-extended in wide mode, zero-extended otherwise.
  function automatic logic [63:0] read_view(input logic [63:0] stored, input int unsigned w,
                                            input logic wide);
    return wide ? fold_to_width(stored, w) : (stored & width_mask(LEGACY_W));
  endfunction
endpackage

// File: rtl/dect_count.sv
module dect_count #(
  parameter int unsigned CW = 56
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic [6:0]    act_w,
  output logic [CW-1:0] cnt,
  output logic          old_msb,
  output logic          underflow
);
  import dect_pkg::*;

  localparam logic [CW-1:0] RST_VAL = CW'(64'h0000_0000_FFFF_FFFF);

  logic [63:0] cnt64;
  logic        zero_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= RST_VAL;
    else if (wr_en) cnt <= wr_val;
    else if (tick)  cnt <= cnt - CW'(1);
  end

  assign cnt64     = 64'(cnt);
  assign zero_act  = ((cnt64 & width_mask(act_w)) == 64'd0);
  assign old_msb   = cnt64[6'(act_w - 7'd1)];
  assign underflow = tick && !wr_en && zero_act;

  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr_en) |=> (cnt == $past(cnt) - CW'(1)));

  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt == $past(wr_val)));
endmodule

// File: rtl/dect_irq.sv
module dect_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_mode,
  input  logic wr_en,
  input  logic wr_neg,
  input  logic wr_small,
  input  logic old_msb,
  input  logic underflow,
  input  logic ack,
  output logic pend
);
  logic set_evt;
  logic clr_evt;
  logic ack_evt;

  assign set_evt = underflow ||
                   (wr_en && (wr_small || (wr_neg && (!edge_mode || !old_msb))));
  assign clr_evt = wr_en && !edge_mode && !wr_neg && !wr_small;
  assign ack_evt = edge_mode && ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend <= 1'b0;
    else if (set_evt)            pend <= 1'b1;
    else if (clr_evt || ack_evt) pend <= 1'b0;
  end

  p_set_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend);

  p_level_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !pend);

  p_level_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_mode && !wr_en && !underflow) |=> (pend == $past(pend)));

  p_edge_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && ack && !set_evt) |=> !pend);

  p_edge_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && !ack && !set_evt) |=> (pend == $past(pend)));
endmodule

// File: rtl/dec_timer.sv
module dec_timer #(
  parameter int unsigned LARGE_W = 56,
  parameter bit          HYPER   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  input  logic        large_mode,
  input  logic        irq_edge,
  input  logic        irq_ack,
  output logic [63:0] rd_data,
  output logic        irq
);
  import dect_pkg::*;

  if (LARGE_W < LEGACY_W || LARGE_W > HYP_MAX_W) begin : g_bad_width
    $error("dec_timer: LARGE_W must lie between 32 and 56");
  end

  logic               large_act;
  logic [6:0]         act_w;
  logic [63:0]        wr_ext;
  logic               wr_neg;
  logic               wr_small;
  logic [LARGE_W-1:0] cnt;
  logic               old_msb;
  logic               underflow;

  assign large_act = HYPER | large_mode;
  assign act_w     = large_act ? 7'(LARGE_W) : 7'(LEGACY_W);
  assign wr_ext    = fold_to_width(wr_data, act_w);
  assign wr_neg    = wr_ext[63];
  assign wr_small  = (wr_ext < 64'd3);

  dect_count #(.CW(LARGE_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .wr_en     (wr_en),
    .wr_val    (wr_ext[LARGE_W-1:0]),
    .act_w     (act_w),
    .cnt       (cnt),
    .old_msb   (old_msb),
    .underflow (underflow)
  );

  dect_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_mode (irq_edge),
    .wr_en     (wr_en),
    .wr_neg    (wr_neg),
    .wr_small  (wr_small),
    .old_msb   (old_msb),
    .underflow (underflow),
    .ack       (irq_ack),
    .pend      (irq)
  );

  assign rd_data = read_view(64'(cnt), LARGE_W, large_act);

  p_wide_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    large_act |-> (rd_data[63] == rd_data[LARGE_W-1]));

  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> irq);
endmodule

// File: tb/sim_dec_timer.sv
module sim_dec_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, large_mode = 1'b0, irq_edge = 1'b0, irq_ack = 1'b0;
  logic [63:0] wr_data = 64'd0;
  logic [63:0] rd_data;
  logic        irq;
  logic        h_wr_en = 1'b0;
  logic [63:0] h_wr_data = 64'd0;
  logic [63:0] h_rd;
  logic        h_irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #5 clk = ~clk;

  dec_timer #(.LARGE_W(40), .HYPER(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .large_mode(large_mode), .irq_edge(irq_edge), .irq_ack(irq_ack),
    .rd_data(rd_data), .irq(irq));

  dec_timer #(.LARGE_W(56), .HYPER(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .tick(1'b0), .wr_en(h_wr_en), .wr_data(h_wr_data),
    .large_mode(1'b0), .irq_edge(1'b0), .irq_ack(1'b0),
    .rd_data(h_rd), .irq(h_irq));

  task automatic chk64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk64("R1 reset value", rd_data, 64'h0000_0000_FFFF_FFFF);
    chk1("R1 reset irq", irq, 1'b0);
  endtask

  task automatic t_legacy_count();
    large_mode = 1'b0; irq_edge = 1'b0;
    wr(64'd100);
    ticks(5);
    chk64("R2 legacy decrement", rd_data, 64'd95);
    chk1("R6 positive write leaves level irq low", irq, 1'b0);
  endtask

  task automatic t_widths();
    large_mode = 1'b1; irq_edge = 1'b0;
    wr(64'h0000_0080_0000_0000);
    chk64("R3 wide sign extension from bit 39", rd_data, 64'hFFFF_FF80_0000_0000);
    chk1("R6 negative write sets level irq", irq, 1'b1);
    ack_pulse();
    chk1("R6 ack ignored in level rule", irq, 1'b1);
    wr(64'hFF00_0012_3456_789A);
    chk64("R4 wide truncation", rd_data, 64'h0000_0012_3456_789A);
    chk1("R6 non-negative write clears level irq", irq, 1'b0);
    large_mode = 1'b0;
    wr(64'h0000_0001_2345_6789);
    chk64("R4 legacy truncation", rd_data, 64'h0000_0000_2345_6789);
    wr(64'h0000_0000_8000_0000);
    chk64("R2 legacy read zero-extended", rd_data, 64'h0000_0000_8000_0000);
    large_mode = 1'b1;
    #1;
    chk64("R4 legacy write sign-extended in wide view", rd_data, 64'hFFFF_FFFF_8000_0000);
    large_mode = 1'b0;
  endtask

  task automatic t_small_writes();
    irq_edge = 1'b1;
    ack_pulse();
    chk1("R7 ack clears edge flag", irq, 1'b0);
    wr(64'd2);
    chk1("R5 write of 2 fires under edge rule", irq, 1'b1);
    ack_pulse();
    irq_edge = 1'b0;
    wr(64'd0);
    chk1("R5 write of 0 fires under level rule", irq, 1'b1);
  endtask

  task automatic t_edge_rules();
    irq_edge = 1'b1;
    wr(64'd1000);
    ack_pulse();
    chk1("R7 cleared before test", irq, 1'b0);
    wr(64'd1000);
    chk1("R7 positive write does not fire", irq, 1'b0);
    wr(64'h0000_0000_FFFF_FFF0);
    chk1("R7 positive-to-negative write fires", irq, 1'b1);
    wr(64'd500);
    chk1("R7 positive write does not clear edge flag", irq, 1'b1);
    wr(64'h0000_0000_FFFF_FFF0);
    ack_pulse();
    chk1("R7 ack clears", irq, 1'b0);
    wr(64'h0000_0000_FFFF_FFE0);
    chk1("R7 negative-to-negative write does not fire", irq, 1'b0);
  endtask

  task automatic t_underflow();
    irq_edge = 1'b0;
    wr(64'd3);
    chk1("R8 level cleared by write of 3", irq, 1'b0);
    ticks(3);
    chk64("R8 count at zero", rd_data, 64'd0);
    chk1("R8 no irq at zero", irq, 1'b0);
    ticks(1);
    chk64("R8 wrap to all-ones", rd_data, 64'h0000_0000_FFFF_FFFF);
    chk1("R8 level underflow fires", irq, 1'b1);
    irq_edge = 1'b1;
    wr(64'd3);
    ack_pulse();
    ticks(3);
    chk1("R8 edge quiet before wrap", irq, 1'b0);
    ticks(1);
    chk1("R8 edge underflow fires", irq, 1'b1);
    ack_pulse();
    irq_edge = 1'b0;
  endtask

  task automatic t_write_vs_tick();
    @(negedge clk); wr_en = 1'b1; wr_data = 64'd50; tick = 1'b1;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
    chk64("R9 write wins over tick", rd_data, 64'd50);
    ticks(1);
    chk64("R9 tick after write", rd_data, 64'd49);
  endtask

  task automatic t_hyper();
    chk64("R10 hyper reset read wide", h_rd, 64'h0000_0000_FFFF_FFFF);
    @(negedge clk); h_wr_en = 1'b1; h_wr_data = 64'h0080_0000_0000_0000;
    @(negedge clk); h_wr_en = 1'b0;
    chk64("R10 hyper sign from bit 55", h_rd, 64'hFF80_0000_0000_0000);
    chk1("R10 hyper negative write fires", h_irq, 1'b1);
    @(negedge clk); h_wr_en = 1'b1; h_wr_data = 64'h0000_0000_8000_0000;
    @(negedge clk); h_wr_en = 1'b0;
    chk64("R10 hyper keeps bit 31 as data", h_rd, 64'h0000_0000_8000_0000);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hyper();
    t_legacy_count();
    t_widths();
    t_small_writes();
    t_edge_rules();
    t_underflow();
    t_write_vs_tick();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule